// File: doc/BRIEF.md
# Six-Output Motor PWM Generator

This block drives the gates of a three-phase inverter or of six separate loads. A free-running period counter is compared against six duty values. The six outputs are either three top/bottom pairs or six independent channels. In paired use the bottom output is the inverse of the top, and a programmable gap is placed on every switch-over so that both switches of a leg are never on together. The counter either ramps up and wraps (edge-aligned) or ramps up and then back down (center-aligned).

Software sets the block up through a simple write port. Modulus and duty writes go to shadow registers. The running copies pick them up only at a reload, which comes once every N periods, and each reload emits a one-cycle sync pulse for converter timing. Four fault inputs shut every output down in the same cycle they rise. The dead time, the polarities, the pairing mode and the fault clear modes sit in a configuration word that accepts only the first write after reset.

Top module: `mc_pwm6`

## Requirements
- R1: Write map (`wr_addr`): 0 modulus M in `wr_data[CW-1:0]`, with 0 treated as 1; 1 to 6 duty of output 0 to 5; 7 control, with bit0 run, bit1 center-aligned and bits[5:2] reload interval minus one; 8 configuration, with bits[7:0] dead time D, bit8 invert even outputs, bit9 invert odd outputs, bit10 independent mode and bits[14:11] manual-clear select for faults 0 to 3; 9 fault acknowledge, with bit i for fault i.
- R2: Edge-aligned mode has a period of M clocks. The counter runs 0..M-1, and a channel is logically active while the counter is below its duty. Outputs show the counter one clock later.
- R3: Center-aligned mode has a period of 2M clocks. The counter runs 0..M-1 and then M-1..0, so a duty d gives 2d active clocks centred on the period boundary.
- R4: A duty of 0 keeps the channel inactive, and a duty of M or more keeps it active, with no dead gap in either case.
- R5: In paired mode (bit10 = 0), output 2k+1 is the complement of output 2k, which follows duty register 2k; the odd duty registers have no effect. After every change of the top output both outputs stay inactive for D clocks.
- R6: In independent mode, each output follows its own duty register with no dead gap.
- R7: Even outputs are XORed with config bit8 and odd outputs with bit9, so the inactive level of each output equals its invert bit.
- R8: Modulus and duty writes take effect only at a reload, which happens at the end of every Nth period, with N from 1 to 16. While the block is stopped the shadow values are copied in continuously.
- R9: `sync_out` is high for exactly the first clock of the period that follows each reload.
- R10: While any fault input is high, all outputs are at their inactive level in that same cycle.
- R11: A fault stays latched until its input falls (automatic) or until the input has fallen and the fault is acknowledged (manual). Outputs resume only at the next period start after all faults have cleared.
- R12: Only the first configuration write after reset is accepted. Later configuration writes are ignored.
- R13: While stopped, the counter is held at zero and all outputs are at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | DTW+3+NF (15) | Write data |
| fault_in | input | NF (4) | Active-high fault inputs |
| pwm_out | output | 6 | Gate outputs, even = top, odd = bottom |
| sync_out | output | 1 | One-clock pulse after each reload |

## Verification
The bench goes after the dead gap at both edges of a pulse. A design that counted the gap wrongly by one clock would show a top pulse one clock too long or too short. It also targets the pinned duty values of 0 and M, where a design that inserted the gap anyway would glitch the bottom output low once per period. The reload interval is measured as the spacing between sync pulses; if duty loads took effect early, the outputs would change mid-interval. A lock that let the second configuration write through would flip the idle level, and a fault latch that released outputs as soon as the input fell would restart them mid-period instead of at the period start.

// File: rtl/mc_pwm6.sv
module mc_pwm6 #(
  parameter int CW = 12,
  parameter int DTW = 8,
  parameter int NF = 4,
  localparam int WW = DTW + 3 + NF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic [NF-1:0] fault_in,
  output logic [5:0]    pwm_out,
  output logic          sync_out
);
  localparam logic [3:0] A_MOD = 4'd0, A_CTRL = 4'd7, A_CFG = 4'd8, A_ACK = 4'd9;
  localparam int F_PT = DTW, F_PB = DTW + 1, F_IND = DTW + 2, F_FM = DTW + 3;

  logic [CW-1:0] mod_b, mod_a, cnt, last_c;
  logic [CW-1:0] duty_b [6];
  logic [CW-1:0] duty_a [6];
  logic run, center, down, locked, shut, sync_q;
  logic [3:0] rdiv, pcnt;
  logic [WW-1:0] cfg;
  logic [NF-1:0] flt;
  logic [5:0] raw, s_d, lg, polm;

  wire [DTW-1:0] dt    = cfg[DTW-1:0];
  wire           indep = cfg[F_IND];
  wire [NF-1:0]  fmode = cfg[F_FM +: NF];
  assign polm   = {3{cfg[F_PB], cfg[F_PT]}};
  assign last_c = (mod_a == '0) ? '0 : mod_a - CW'(1);

  wire at_top = cnt >= last_c;
  wire pstart = (cnt == '0) && !down;
  wire wrap   = center ? (down && cnt == '0) : at_top;
  wire turn   = center && !down && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_b  <= '0;
      run    <= 1'b0;
      center <= 1'b0;
      rdiv   <= '0;
      cfg    <= '0;
      locked <= 1'b0;
      for (int i = 0; i < 6; i++) duty_b[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MOD) mod_b <= wr_data[CW-1:0];
      if (wr_addr == A_CTRL) begin
        run    <= wr_data[0];
        center <= wr_data[1];
        rdiv   <= wr_data[5:2];
      end
      if (wr_addr == A_CFG && !locked) begin
        cfg    <= wr_data;
        locked <= 1'b1;
      end
      for (int i = 0; i < 6; i++)
        if (wr_addr == 4'(i + 1)) duty_b[i] <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      down   <= 1'b0;
      pcnt   <= '0;
      sync_q <= 1'b0;
      mod_a  <= '0;
      for (int i = 0; i < 6; i++) duty_a[i] <= '0;
    end else if (!run) begin
      cnt    <= '0;
      down   <= 1'b0;
      pcnt   <= '0;
      sync_q <= 1'b0;
      mod_a  <= mod_b;
      for (int i = 0; i < 6; i++) duty_a[i] <= duty_b[i];
    end else if (wrap) begin
      cnt  <= '0;
      down <= 1'b0;
      if (pcnt == rdiv) begin
        pcnt   <= '0;
        sync_q <= 1'b1;
        mod_a  <= mod_b;
        for (int i = 0; i < 6; i++) duty_a[i] <= duty_b[i];
      end else begin
        pcnt   <= pcnt + 4'd1;
        sync_q <= 1'b0;
      end
    end else begin
      sync_q <= 1'b0;
      if (turn) down <= 1'b1;
      else if (down) cnt <= cnt - CW'(1);
      else cnt <= cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < 6; i++) begin : g_cmp
    assign raw[i] = cnt < duty_a[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_d <= '0;
    else s_d <= run ? raw : '0;
  end

  for (genvar k = 0; k < 3; k++) begin : g_pair
    logic [DTW-1:0] dtc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dtc <= '0;
      else if (!run) dtc <= '0;
      else if (raw[2*k] != s_d[2*k]) dtc <= dt;
      else if (dtc != '0) dtc <= dtc - DTW'(1);
    end
    assign lg[2*k]   = indep ? s_d[2*k]   : ( s_d[2*k] && dtc == '0);
    assign lg[2*k+1] = indep ? s_d[2*k+1] : (!s_d[2*k] && dtc == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt  <= '0;
      shut <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (fault_in[i]) flt[i] <= 1'b1;
        else if (!fmode[i]) flt[i] <= 1'b0;
        else if (wr_en && wr_addr == A_ACK && wr_data[i]) flt[i] <= 1'b0;
      end
      if (|fault_in || |flt) shut <= 1'b1;
      else if (pstart) shut <= 1'b0;
    end
  end

  wire en = run && !shut && !(|fault_in);
  assign pwm_out  = (en ? lg : 6'b0) ^ polm;
  assign sync_out = sync_q;
endmodule

// File: rtl/mc_pwm6_chk.sv
module mc_pwm6_chk #(
  parameter int CW = 12,
  parameter int DTW = 8,
  parameter int NF = 4,
  parameter int WW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [NF-1:0] fault_in,
  input logic [5:0]    pwm_out,
  input logic [5:0]    polm,
  input logic [5:0]    lg,
  input logic          sync_out,
  input logic          run,
  input logic          down,
  input logic          indep,
  input logic          locked,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] last_c,
  input logic [DTW-1:0] dt,
  input logic [WW-1:0] cfg
);
  p_fault_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |-> (pwm_out == polm));

  p_stop_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == polm));

  p_sync_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (cnt == '0 && !down));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last_c));

  p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!indep && dt != '0 && $fell(lg[0])) |-> !lg[1]);

  p_cfg_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && wr_addr == 4'd8) |=> $stable(cfg));
endmodule

bind mc_pwm6 mc_pwm6_chk #(.CW(CW), .DTW(DTW), .NF(NF), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .fault_in(fault_in), .pwm_out(pwm_out), .polm(polm), .lg(lg),
  .sync_out(sync_out), .run(run), .down(down), .indep(indep),
  .locked(locked), .cnt(cnt), .last_c(last_c), .dt(dt), .cfg(cfg)
);

// File: tb/sim_mc_pwm6.sv
`timescale 1ns/1ps
module sim_mc_pwm6;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [14:0] wr_data = '0;
  logic [3:0] fault_in = '0;
  logic [5:0] pwm_out;
  logic sync_out;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R13";

  always #2 clk = ~clk;

  mc_pwm6 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
              .wr_data(wr_data), .fault_in(fault_in), .pwm_out(pwm_out),
              .sync_out(sync_out));

  // behavioural reference
  int m_mod_b, m_mod_a, m_n, m_dt, m_p, m_pc;
  int m_db[6], m_da[6], m_since[3];
  bit m_run, m_ctr, m_pt, m_pb, m_ind, m_lock, m_sync, m_shut;
  bit m_sd[6];
  bit [3:0] m_fm, m_flt;

  function automatic int m_cnt();
    int mm = (m_mod_a == 0) ? 1 : m_mod_a;
    if (!m_ctr) return m_p;
    return (m_p < mm) ? m_p : 2*mm - 1 - m_p;
  endfunction

  function automatic bit [5:0] m_out();
    bit [5:0] r;
    bit en = m_run && !m_shut && (fault_in == 0);
    for (int i = 0; i < 6; i++) begin
      bit l;
      if (m_ind) l = m_sd[i];
      else if (i % 2 == 0) l = m_sd[i] && (m_since[i/2] >= m_dt);
      else l = !m_sd[i-1] && (m_since[i/2] >= m_dt);
      r[i] = (en && l) ^ ((i % 2 == 0) ? m_pt : m_pb);
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mod_b = 0; m_mod_a = 0; m_n = 1; m_dt = 0; m_p = 0; m_pc = 0;
      m_run = 0; m_ctr = 0; m_pt = 0; m_pb = 0; m_ind = 0; m_lock = 0;
      m_sync = 0; m_shut = 0; m_fm = 0; m_flt = 0;
      for (int i = 0; i < 6; i++) begin m_db[i] = 0; m_da[i] = 0; m_sd[i] = 0; end
      for (int k = 0; k < 3; k++) m_since[k] = 1000;
    end else begin
      int mm, last, c;
      bit raw[6];
      bit [3:0] nflt;
      mm = (m_mod_a == 0) ? 1 : m_mod_a;
      last = m_ctr ? 2*mm - 1 : mm - 1;
      c = m_cnt();
      for (int i = 0; i < 6; i++) raw[i] = c < m_da[i];
      for (int i = 0; i < 4; i++) begin
        if (fault_in[i]) nflt[i] = 1;
        else if (!m_fm[i]) nflt[i] = 0;
        else if (wr_en && wr_addr == 9 && wr_data[i]) nflt[i] = 0;
        else nflt[i] = m_flt[i];
      end
      if (fault_in != 0 || m_flt != 0) m_shut = 1;
      else if (m_p == 0) m_shut = 0;
      m_flt = nflt;
      if (!m_run) begin
        for (int i = 0; i < 6; i++) m_sd[i] = 0;
        for (int k = 0; k < 3; k++) m_since[k] = 1000;
      end else begin
        for (int k = 0; k < 3; k++)
          if (raw[2*k] != m_sd[2*k]) m_since[k] = 0;
          else if (m_since[k] < 1000) m_since[k]++;
        for (int i = 0; i < 6; i++) m_sd[i] = raw[i];
      end
      if (!m_run) begin
        m_p = 0; m_pc = 0; m_sync = 0; m_mod_a = m_mod_b;
        for (int i = 0; i < 6; i++) m_da[i] = m_db[i];
      end else if (m_p >= last) begin
        m_p = 0;
        if (m_pc == m_n - 1) begin
          m_pc = 0; m_sync = 1; m_mod_a = m_mod_b;
          for (int i = 0; i < 6; i++) m_da[i] = m_db[i];
        end else begin
          m_pc++; m_sync = 0;
        end
      end else begin
        m_p++; m_sync = 0;
      end
      if (wr_en) begin
        if (wr_addr == 0) m_mod_b = wr_data[11:0];
        if (wr_addr >= 1 && wr_addr <= 6) m_db[wr_addr-1] = wr_data[11:0];
        if (wr_addr == 7) begin
          m_run = wr_data[0]; m_ctr = wr_data[1]; m_n = wr_data[5:2] + 1;
        end
        if (wr_addr == 8 && !m_lock) begin
          m_dt = wr_data[7:0]; m_pt = wr_data[8]; m_pb = wr_data[9];
          m_ind = wr_data[10]; m_fm = wr_data[14:11]; m_lock = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    bit [5:0] e;
    e = m_out();
    n_chk++;
    if (pwm_out !== e || sync_out !== m_sync) begin
      n_fail++;
      $display("FAIL %s cycle compare: out=%b sync=%b expected out=%b sync=%b",
               cur_req, pwm_out, sync_out, e, m_sync);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 4'(a); wr_data = 15'(d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic count_hi(int idx, int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); c += int'(pwm_out[idx]); end
  endtask

  task automatic sync_gap(output int c);
    do @(negedge clk); while (!sync_out);
    c = 0;
    do begin @(negedge clk); c++; end while (!sync_out && c < 5000);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    cyc(3);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    int c;
    cyc(3); rst_n = 1; cyc(1);
    @(negedge clk);
    chk("R13 reset outputs", pwm_out, 0);
    chk("R9 reset sync", sync_out, 0);

    cur_req = "R12";
    wr(8, 2 | (1 << 12));
    wr(8, 5 | (1 << 8) | (1 << 9));
    @(negedge clk);
    chk("R12 second config ignored", pwm_out, 0);

    cur_req = "R1";
    wr(0, 10); wr(1, 3); wr(2, 7); wr(3, 0); wr(4, 9); wr(5, 10); wr(6, 1);
    wr(7, 1);
    cyc(25);
    cur_req = "R5";
    count_hi(0, 10, c); chk("R5 top on cycles", c, 1);
    count_hi(1, 10, c); chk("R5 bottom on cycles", c, 5);
    cur_req = "R4";
    count_hi(2, 10, c); chk("R4 duty 0 top", c, 0);
    count_hi(3, 10, c); chk("R4 duty 0 bottom", c, 10);
    count_hi(4, 10, c); chk("R4 full duty top", c, 10);
    count_hi(5, 10, c); chk("R4 full duty bottom", c, 0);
    cur_req = "R2";
    sync_gap(c); chk("R2 edge period", c, 10);

    cur_req = "R8";
    wr(7, 1 | (2 << 2));
    wr(1, 6);
    sync_gap(c); chk("R8 reload every 3 periods", c, 30);
    count_hi(0, 10, c); chk("R8 new duty after reload", c, 4);

    cur_req = "R13";
    wr(7, 0);
    cyc(2); @(negedge clk);
    chk("R13 stopped idle", pwm_out, 0);
    cur_req = "R3";
    wr(0, 8); wr(1, 3);
    wr(7, 3);
    cyc(40);
    count_hi(0, 16, c); chk("R3 center top", c, 4);
    count_hi(1, 16, c); chk("R3 center bottom", c, 8);
    sync_gap(c); chk("R3 center period", c, 16);

    do_reset();
    cur_req = "R6";
    wr(8, (1 << 8) | (1 << 10) | (1 << 12));
    wr(0, 10); wr(1, 2); wr(2, 5);
    wr(7, 1);
    cyc(25);
    cur_req = "R7";
    count_hi(0, 10, c); chk("R7 inverted even output", c, 8);
    count_hi(2, 10, c); chk("R7 inverted idle even output", c, 10);
    cur_req = "R6";
    count_hi(1, 10, c); chk("R6 independent odd output", c, 5);
    count_hi(3, 10, c); chk("R6 independent duty 0", c, 0);

    cur_req = "R10";
    cyc(3);
    fault_in = 4'b0001;
    @(negedge clk); chk("R10 fault forces idle", pwm_out, 6'b010101);
    cyc(3);
    fault_in = 4'b0000;
    @(negedge clk); chk("R11 no resume mid-period", pwm_out, 6'b010101);
    cur_req = "R11";
    cyc(20);
    fault_in = 4'b0010;
    cyc(2);
    fault_in = 4'b0000;
    cyc(30);
    @(negedge clk); chk("R11 manual fault held", pwm_out, 6'b010101);
    wr(9, 2);
    cyc(25);
    count_hi(1, 10, c); chk("R11 resume after acknowledge", c, 5);

    finish_run();
  end
endmodule